// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. A request carries the virtual address and the base address of the top-level directory. The walker fetches one directory entry, which names the second-level table, then fetches one entry of that table, which names the physical page frame. The frame is joined with the untouched in-page offset and returned with a one-cycle done strobe. If either fetched entry is marked absent, the walk stops at once and reports a fault.

Pages are 8 KB. The address splits into an 8-bit directory index (bits 31:24, 16 MB per directory slot), an 11-bit table index (bits 23:13, 2048 slots per table, so one 4-byte-entry table fills exactly one page) and a 13-bit offset. There is no middle level: a directory entry points straight at a second-level table. For example, virtual address 0xD004000C uses directory slot 0xD0, table slot 0x020 and offset 0x00C.

Memory is reached through a single-outstanding read port: the walker raises a request with an address and holds it until the memory accepts it, then waits for one response beat before it issues anything else. A new walk is taken only when the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: On a walk that succeeds, the result address equals bits 31:13 of the fetched table entry followed by bits 12:0 of the virtual address, with walk_fault low.
- R2: The first memory read of a walk goes to directory base + 4 × vaddr[31:24], modulo 2^32.
- R3: The second memory read goes to the directory entry with its bits 12:0 cleared, plus 4 × vaddr[23:13], modulo 2^32.
- R4: Bit 0 of every entry is its present flag. If the directory entry has bit 0 equal to 0, the walk ends with walk_fault high, walk_paddr zero, and exactly one memory read made.
- R5: If the directory entry is present but the table entry has bit 0 equal to 0, the walk ends with walk_fault high, walk_paddr zero, and exactly two memory reads made.
- R6: Every accepted request yields exactly one walk_done pulse, one clock cycle long.
- R7: req_ready is high only while the walker is idle; req_valid while busy is ignored and does not alter the walk in progress.
- R8: A memory request keeps mem_req_valid high and mem_req_addr unchanged until mem_req_ready is seen, and no new request is raised until the response to the previous one has arrived.
- R9: After reset, req_ready is high, walk_done is low and mem_req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | Walker is idle and takes the request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_dir_base | input | 32 | Byte address of the top-level directory |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry read from memory |
| walk_done | output | 1 | One-cycle strobe: result is valid |
| walk_fault | output | 1 | The walk hit an absent entry |
| walk_paddr | output | 32 | Translated physical address, zero on fault |

## Verification
Assertions watch the memory port handshake on every cycle: a pending read must hold its address until taken and must drop once taken, the done strobe never lasts two cycles, the idle indication drops after a request is taken, and any result carries the request's offset or, on a fault, a zero address. Which address each read targets, how many reads a faulting walk makes, and the frame value returned are only visible in the bench's scenarios, where a memory model with random acceptance and latency serves entries whose present flags are forced or left random, and busy-time requests with other addresses are offered to show they are dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READ_DIR = 3'd1,
        ST_WAIT_DIR = 3'd2,
        ST_READ_PTE = 3'd3,
        ST_WAIT_PTE = 3'd4,
        ST_DONE     = 3'd5
    } walk_state_e;

endpackage

// File: rtl/ptw_index_split.sv
module ptw_index_split #(
    parameter int ADDR_W   = 32,
    parameter int DIR_BITS = 8,
    parameter int OFF_BITS = 13,
    localparam int TBL_BITS = ADDR_W - DIR_BITS - OFF_BITS
) (
    input  logic [ADDR_W-1:0]   vaddr,
    output logic [DIR_BITS-1:0] dir_idx,
    output logic [TBL_BITS-1:0] tbl_idx,
    output logic [OFF_BITS-1:0] page_off
);
    assign dir_idx  = vaddr[ADDR_W-1 -: DIR_BITS];
    assign tbl_idx  = vaddr[OFF_BITS +: TBL_BITS];
    assign page_off = vaddr[OFF_BITS-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 8,
    parameter int ENTRY_BYTES = 4,
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES)
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [ADDR_W-1:0] byte_off;

    assign byte_off   = {{(ADDR_W-IDX_W){1'b0}}, index} << ENTRY_SHIFT;
    assign entry_addr = table_base + byte_off;
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ADDR_W      = 32,
    parameter int OFF_BITS    = 13,
    parameter int PRESENT_BIT = 0
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              present,
    output logic [ADDR_W-1:0] frame_base
);
    logic unused_low_bits;

    assign present         = entry[PRESENT_BIT];
    assign frame_base      = {entry[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
    assign unused_low_bits = ^entry[OFF_BITS-1:0];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DIR_BITS    = 8,
    parameter int OFF_BITS    = 13,
    parameter int ENTRY_BYTES = 4,
    parameter int PRESENT_BIT = 0,
    localparam int TBL_BITS   = ADDR_W - DIR_BITS - OFF_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_dir_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              walk_done,
    output logic              walk_fault,
    output logic [ADDR_W-1:0] walk_paddr
);

    typedef struct packed {
        walk_state_e       state;
        logic [ADDR_W-1:0] vaddr;
        logic [ADDR_W-1:0] dir_base;
        logic [ADDR_W-1:0] tbl_base;
        logic [ADDR_W-1:0] paddr;
        logic              fault;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic [DIR_BITS-1:0] dir_idx;
    logic [TBL_BITS-1:0] tbl_idx;
    logic [OFF_BITS-1:0] page_off;
    logic [ADDR_W-1:0]   dir_entry_addr;
    logic [ADDR_W-1:0]   pte_entry_addr;
    logic                rsp_present;
    logic [ADDR_W-1:0]   rsp_frame;

    ptw_index_split #(
        .ADDR_W  (ADDR_W),
        .DIR_BITS(DIR_BITS),
        .OFF_BITS(OFF_BITS)
    ) u_split (
        .vaddr   (walk_q.vaddr),
        .dir_idx (dir_idx),
        .tbl_idx (tbl_idx),
        .page_off(page_off)
    );

    ptw_entry_addr #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (DIR_BITS),
        .ENTRY_BYTES(ENTRY_BYTES)
    ) u_dir_addr (
        .table_base(walk_q.dir_base),
        .index     (dir_idx),
        .entry_addr(dir_entry_addr)
    );

    ptw_entry_addr #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (TBL_BITS),
        .ENTRY_BYTES(ENTRY_BYTES)
    ) u_pte_addr (
        .table_base(walk_q.tbl_base),
        .index     (tbl_idx),
        .entry_addr(pte_entry_addr)
    );

    ptw_entry_decode #(
        .ADDR_W     (ADDR_W),
        .OFF_BITS   (OFF_BITS),
        .PRESENT_BIT(PRESENT_BIT)
    ) u_decode (
        .entry     (mem_rsp_data),
        .present   (rsp_present),
        .frame_base(rsp_frame)
    );

    // Next-state logic for the whole walk.
    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.vaddr    = req_vaddr;
                    walk_d.dir_base = req_dir_base;
                    walk_d.paddr    = '0;
                    walk_d.fault    = 1'b0;
                    walk_d.state    = ST_READ_DIR;
                end
            end
            ST_READ_DIR: begin
                if (mem_req_ready) walk_d.state = ST_WAIT_DIR;
            end
            ST_WAIT_DIR: begin
                if (mem_rsp_valid) begin
                    if (rsp_present) begin
                        walk_d.tbl_base = rsp_frame;
                        walk_d.state    = ST_READ_PTE;
                    end else begin
                        walk_d.fault = 1'b1;
                        walk_d.paddr = '0;
                        walk_d.state = ST_DONE;
                    end
                end
            end
            ST_READ_PTE: begin
                if (mem_req_ready) walk_d.state = ST_WAIT_PTE;
            end
            ST_WAIT_PTE: begin
                if (mem_rsp_valid) begin
                    if (rsp_present) begin
                        walk_d.paddr = rsp_frame | {{(ADDR_W-OFF_BITS){1'b0}}, page_off};
                        walk_d.fault = 1'b0;
                    end else begin
                        walk_d.paddr = '0;
                        walk_d.fault = 1'b1;
                    end
                    walk_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                walk_d.state = ST_IDLE;
            end
            default: begin
                walk_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{state: ST_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.state == ST_IDLE);
    assign mem_req_valid = (walk_q.state == ST_READ_DIR) || (walk_q.state == ST_READ_PTE);
    assign mem_req_addr  = (walk_q.state == ST_READ_PTE) ? pte_entry_addr : dir_entry_addr;
    assign walk_done     = (walk_q.state == ST_DONE);
    assign walk_fault    = walk_q.fault;
    assign walk_paddr    = walk_q.paddr;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done); // R6
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !walk_done); // R7
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && walk_fault |-> walk_paddr == '0); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && !walk_fault |-> walk_paddr[OFF_BITS-1:0] == walk_q.vaddr[OFF_BITS-1:0]); // R1

endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_dir_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        walk_done;
    logic        walk_fault;
    logic [31:0] walk_paddr;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;

    // Memory model control: 0 random present bits, 1 all present,
    // 2 directory absent, 3 directory present and table entry absent.
    int unsigned mode = 0;
    int unsigned rd_cnt = 0;
    logic [31:0] rd_addr [2];
    int unsigned n_ok = 0, n_dfault = 0, n_pfault = 0;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_dir_base(req_dir_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .walk_done(walk_done),
        .walk_fault(walk_fault), .walk_paddr(walk_paddr)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] hash32(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ (a >> 11) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a, input int unsigned idx);
        logic [31:0] h = hash32(a);
        case (mode)
            1: return h | 32'd1;
            2: return (idx == 0) ? (h & ~32'd1) : (h | 32'd1);
            3: return (idx == 0) ? (h | 32'd1) : (h & ~32'd1);
            default: return h;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: random acceptance delay and response latency.
    initial begin
        int unsigned lat = 0;
        bit pend = 0;
        logic [31:0] lat_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                pend = 1;
                lat = $urandom % 3;
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(lat_addr, rd_cnt);
                    if (rd_cnt < 2) rd_addr[rd_cnt] = lat_addr;
                    rd_cnt++;
                    pend = 0;
                end else begin
                    lat--;
                end
            end else if (mem_req_valid && ($urandom % 2 == 0)) begin
                mem_req_ready = 1'b1;
                lat_addr = mem_req_addr;
            end
        end
    end

    task automatic do_walk(input logic [31:0] va, input logic [31:0] base, input bit noise);
        logic [31:0] d_addr, d, t_addr, p, e_pa;
        bit e_fault;
        int unsigned e_reads;
        int unsigned waited = 0;
        d_addr = base + {22'd0, va[31:24], 2'b00};
        d = mem_word(d_addr, 0);
        t_addr = {d[31:13], 13'd0} + {19'd0, va[23:13], 2'b00};
        p = mem_word(t_addr, 1);
        if (!d[0]) begin e_fault = 1; e_reads = 1; e_pa = 0; end
        else if (!p[0]) begin e_fault = 1; e_reads = 2; e_pa = 0; end
        else begin e_fault = 0; e_reads = 2; e_pa = {p[31:13], va[12:0]}; end

        check(req_ready === 1'b1, "R7", "ready while idle", {31'd0, req_ready}, 32'd1);
        rd_cnt = 0;
        req_vaddr = va;
        req_dir_base = base;
        req_valid = 1'b1;
        @(negedge clk);
        if (noise) begin
            req_vaddr = $urandom;
            req_dir_base = $urandom;
        end else begin
            req_valid = 1'b0;
        end
        while (!walk_done && waited < 100) begin
            check(req_ready === 1'b0, "R7", "ready while busy", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        check(walk_done === 1'b1, "R6", "done seen", {31'd0, walk_done}, 32'd1);
        check(walk_fault === e_fault, e_fault ? (e_reads == 1 ? "R4" : "R5") : "R1",
              "fault flag", {31'd0, walk_fault}, {31'd0, e_fault});
        check(walk_paddr === e_pa, e_fault ? (e_reads == 1 ? "R4" : "R5") : "R1",
              "physical address", walk_paddr, e_pa);
        check(rd_cnt == e_reads, e_reads == 1 ? "R4" : "R5", "read count", rd_cnt, e_reads);
        check(rd_addr[0] === d_addr, "R2", "directory read address", rd_addr[0], d_addr);
        if (e_reads == 2)
            check(rd_addr[1] === t_addr, "R3", "table read address", rd_addr[1], t_addr);
        if (!e_fault) n_ok++;
        else if (e_reads == 1) n_dfault++;
        else n_pfault++;
        @(negedge clk);
        check(walk_done === 1'b0, "R6", "done one cycle", {31'd0, walk_done}, 32'd0);
        check(rd_cnt == e_reads, "R6", "no extra reads", rd_cnt, e_reads);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R9", "reset ready", {31'd0, req_ready}, 32'd1);
        check(walk_done === 1'b0, "R9", "reset done", {31'd0, walk_done}, 32'd0);
        check(mem_req_valid === 1'b0, "R9", "reset mem request", {31'd0, mem_req_valid}, 32'd0);

        // Directed corner cases.
        mode = 1; do_walk(32'hD004000C, 32'h0010_0000, 0);   // R1 R2 R3 worked example
        mode = 1; do_walk(32'hFFFFFFFF, 32'hFFFF_FF00, 1);   // R2 wraparound, R7 noise
        mode = 1; do_walk(32'h0000_0000, 32'h0000_0000, 0);
        mode = 2; do_walk(32'h1234_5678, 32'h0002_0000, 1);  // R4
        mode = 3; do_walk(32'hABCD_EF01, 32'h0003_0000, 0);  // R5

        // Random walks.
        for (int i = 0; i < 300; i++) begin
            mode = $urandom % 4;
            do_walk($urandom, $urandom, $urandom % 2);
        end

        check(n_ok > 0, "R1", "successful walks seen", n_ok, 32'd1);
        check(n_dfault > 0, "R4", "directory faults seen", n_dfault, 32'd1);
        check(n_pfault > 0, "R5", "table faults seen", n_pfault, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule